// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits behind a 16-bit register port. An 8-bit up-counter advances once per tick of a prescaler whose division ratio is picked from eight fixed values. Software keeps the system alive by reloading the counter before it wraps. If the counter wraps while the block is in watchdog mode, a sticky overflow flag is set. If resets are enabled, a reset request is also driven to the system reset controller for a fixed number of clocks. In interval mode a wrap only sets a status bit in the control register.

Each of the three registers accepts a write only when the upper byte of the written word holds that register's key. A write with any other upper byte leaves every register untouched, so a runaway program is unlikely to stop the timer by accident. The overflow flag has a second guard. It can be cleared only by one exact 16-bit word, and only after software has read the reset-control register while the flag was set.

Register map (byte offsets): 0 is control, 2 is counter, 4 is reset control. Control read value: bit 7 is the interval status, bit 6 is the mode (1 = watchdog), bit 5 is the run enable, and bits 2:0 are the clock select. Counter read value: bits 7:0. Reset-control read value: bit 7 is the overflow flag and bit 6 is the reset enable. All other bits read as zero.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset, all three registers read 0x0000 and `rst_req` is low.
- R2: A write to offset 0 takes effect only when bits 15:8 are 0xA5. It then loads mode from bit 6, run enable from bit 5 and clock select from bits 2:0. Any other upper byte leaves the register unchanged.
- R3: A write to offset 2 loads bits 7:0 into the counter only when bits 15:8 are 0x5A. Any other upper byte leaves the counter unchanged.
- R4: While running, the counter increments once every N input clocks. N is 1, 4, 16, 32, 64, 256 and 1024 for clock selects 0 to 6. The first increment lands N clocks after the enabling write.
- R5: Clock select 7 divides by 16384. With the counter loaded to 255, the counter wraps exactly 16384 clocks after the enabling write, and not earlier.
- R6: While the run enable is 0, the counter holds its value.
- R7: A wrap from 255 to 0 in watchdog mode sets the overflow flag (reset-control bit 7), and the counter continues from 0.
- R8: A wrap in watchdog mode with reset enable 1 drives `rst_req` high for exactly 8 consecutive clocks, starting the clock after the wrap. With reset enable 0, `rst_req` stays low.
- R9: A write to offset 4 with bits 15:8 equal to 0x5A loads the reset enable from bit 6. Any other upper byte leaves the reset enable unchanged.
- R10: A write of exactly 0xA500 to offset 4 clears the overflow flag only if offset 4 has been read while the flag was set since the flag was last cleared. Otherwise the flag stays set. A near-miss word such as 0xA501 never clears it.
- R11: A wrap in interval mode sets control bit 7 and leaves the overflow flag and `rst_req` alone. A keyed control write with bit 7 = 0 clears that bit, and a keyed write with bit 7 = 1 keeps it.
- R12: A keyed counter write also restarts the prescaler phase, so the next increment comes a full N clocks after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe (arms the flag clear on offset 4) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write word, key in bits 15:8 |
| bus_rdata | output | 16 | Read value of the addressed register |
| rst_req | output | 1 | Reset request pulse to the system |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a slowest divide of 16384 and an 8-clock reset pulse. It reaches the slowest divider within budget by preloading 255, which leaves a single tick before the wrap. It uses clock select 0 with the same preload to cause further wraps within one clock. This brings the clear guard, interval status and reset-enable cases within reach in a handful of cycles. Randomised keyed and unkeyed writes, with the run enable held off, exercise every key check against a bench model of the registers.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam logic [7:0]  KEY_CTRL   = 8'hA5;
  localparam logic [7:0]  KEY_COUNT  = 8'h5A;
  localparam logic [7:0]  KEY_RSTCTL = 8'h5A;
  localparam logic [15:0] FLAG_CLEAR_WORD = 16'hA500;

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_COUNT  = 3'd2;
  localparam logic [2:0] OFS_RSTCTL = 3'd4;

  localparam int unsigned NUM_SEL = 8;

  typedef struct packed {
    logic       wdog;
    logic       run;
    logic [2:0] sel;
  } ctrl_t;

  // log2 of the prescale ratio for each clock select
  function automatic int unsigned sel_shift(input int unsigned sel,
                                            input int unsigned slowest);
    case (sel)
      0:       sel_shift = 0;
      1:       sel_shift = 2;
      2:       sel_shift = 4;
      3:       sel_shift = 5;
      4:       sel_shift = 6;
      5:       sel_shift = 8;
      6:       sel_shift = 10;
      default: sel_shift = slowest;
    endcase
  endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
#(
  parameter int unsigned SLOW_SHIFT = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);

  localparam int unsigned PW = SLOW_SHIFT;

  logic [PW-1:0]      phase_q;
  logic [PW-1:0]      phase_d;
  logic [NUM_SEL-1:0] sel_hit;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    localparam int unsigned SH = sel_shift(g, SLOW_SHIFT);
    localparam logic [PW-1:0] MASK = PW'((64'd1 << SH) - 64'd1);
    assign sel_hit[g] = &(phase_q | ~MASK);
  end

  always_comb begin
    if (!run || restart) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign tick = run && !restart && sel_hit[sel];

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = tick || load;
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = tick && !load && (cnt_q == CNT_TOP);

endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req
);

  localparam int unsigned W = $clog2(PULSE_LEN + 1);

  logic [W-1:0] left_q;
  logic [W-1:0] left_d;

  always_comb begin
    if (fire)              left_d = W'(PULSE_LEN);
    else if (left_q != '0) left_d = left_q - 1'b1;
    else                   left_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign req = (left_q != '0);

endmodule

// File: rtl/wdg_regif.sv
module wdg_regif
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  output ctrl_t            ctrl,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output logic             rst_en,
  output logic             wd_flag,
  output logic             fire
);

  ctrl_t ctrl_q, ctrl_d;
  logic  rst_en_q, rst_en_d;
  logic  wd_flag_q, wd_flag_d;
  logic  iv_flag_q, iv_flag_d;
  logic  armed_q, armed_d;

  logic       ctrl_we, rstctl_we, clear_req, clear_ok, arm_rd;
  logic       wd_wrap, iv_wrap;
  logic [7:0] key;
  logic       unused_bits;

  assign key         = bus_wdata[15:8];
  assign unused_bits = ^bus_wdata[4:3];

  always_comb begin
    ctrl_we   = bus_wr && (bus_addr == OFS_CTRL)   && (key == KEY_CTRL);
    cnt_load  = bus_wr && (bus_addr == OFS_COUNT)  && (key == KEY_COUNT);
    rstctl_we = bus_wr && (bus_addr == OFS_RSTCTL) && (key == KEY_RSTCTL);
    clear_req = bus_wr && (bus_addr == OFS_RSTCTL) && (bus_wdata == FLAG_CLEAR_WORD);
    arm_rd    = bus_rd && (bus_addr == OFS_RSTCTL) && wd_flag_q;
    clear_ok  = clear_req && armed_q;
    wd_wrap   = wrap &&  ctrl_q.wdog;
    iv_wrap   = wrap && !ctrl_q.wdog;
  end

  assign cnt_load_val = bus_wdata[CNT_W-1:0];

  // next-state logic
  always_comb begin
    ctrl_d   = ctrl_we   ? '{wdog: bus_wdata[6], run: bus_wdata[5], sel: bus_wdata[2:0]} : ctrl_q;
    rst_en_d = rstctl_we ? bus_wdata[6] : rst_en_q;

    if (wd_wrap)       wd_flag_d = 1'b1;
    else if (clear_ok) wd_flag_d = 1'b0;
    else               wd_flag_d = wd_flag_q;

    if (clear_ok && !wd_wrap) armed_d = 1'b0;
    else if (arm_rd)          armed_d = 1'b1;
    else                      armed_d = armed_q;

    if (iv_wrap)      iv_flag_d = 1'b1;
    else if (ctrl_we) iv_flag_d = iv_flag_q & bus_wdata[7];
    else              iv_flag_d = iv_flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rst_en_q <= 1'b0;
    else if (rstctl_we) rst_en_q <= rst_en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_flag_q <= 1'b0;
      iv_flag_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      wd_flag_q <= wd_flag_d;
      iv_flag_q <= iv_flag_d;
      armed_q   <= armed_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL:   bus_rdata = {8'h00, iv_flag_q, ctrl_q.wdog, ctrl_q.run, 2'b00, ctrl_q.sel};
      OFS_COUNT:  bus_rdata = 16'(cnt);
      OFS_RSTCTL: bus_rdata = {8'h00, wd_flag_q, rst_en_q, 6'b000000};
      default:    bus_rdata = 16'h0000;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign rst_en  = rst_en_q;
  assign wd_flag = wd_flag_q;
  assign fire    = wd_wrap && rst_en_q;

endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SLOW_SHIFT = 14,
  parameter int unsigned PULSE_LEN  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rst_req
);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cnt_load_val_w;
  logic             cnt_load_w;
  logic             tick_w;
  logic             wrap_w;
  logic             rst_en_w;
  logic             wd_flag_w;
  logic             fire_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  wdg_regif #(.CNT_W(CNT_W)) u_regif (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .cnt          (cnt_w),
    .wrap         (wrap_w),
    .ctrl         (ctrl_w),
    .cnt_load     (cnt_load_w),
    .cnt_load_val (cnt_load_val_w),
    .rst_en       (rst_en_w),
    .wd_flag      (wd_flag_w),
    .fire         (fire_w)
  );

  wdg_prescaler #(.SLOW_SHIFT(SLOW_SHIFT)) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (ctrl_w.run),
    .restart (cnt_load_w),
    .sel     (ctrl_w.sel),
    .tick    (tick_w)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick_w),
    .load     (cnt_load_w),
    .load_val (cnt_load_val_w),
    .cnt      (cnt_w),
    .wrap     (wrap_w)
  );

  wdg_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_rst_pulse (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .fire  (fire_w),
    .req   (rst_req)
  );

endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PULSE_LEN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [15:0]      bus_wdata,
  input logic             rst_req,
  input ctrl_t            ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic             wd_flag,
  input logic             rst_en
);

  localparam int unsigned RW = $clog2(PULSE_LEN + 1) + 1;

  logic [RW-1:0] run_len;
  logic          seen_q;
  logic          cnt_keyed;

  assign cnt_keyed = bus_wr && (bus_addr == OFS_COUNT) && (bus_wdata[15:8] == KEY_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      seen_q  <= 1'b0;
    end else begin
      run_len <= rst_req ? run_len + 1'b1 : '0;
      seen_q  <= wd_flag ? (seen_q || (bus_rd && bus_addr == OFS_RSTCTL)) : 1'b0;
    end
  end

  assert_ctrl_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CTRL && bus_wdata[15:8] != KEY_CTRL) |=> $stable(ctrl));

  assert_count_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_COUNT && bus_wdata[15:8] != KEY_COUNT && !ctrl.run) |=> $stable(cnt));

  assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !cnt_keyed) |=> $stable(cnt));

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> $past(ctrl.wdog && ctrl.run));

  assert_pulse_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (run_len < RW'(PULSE_LEN)));

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (run_len == RW'(PULSE_LEN)));

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (wd_flag && $past(rst_en)));

  assert_clear_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_flag) |-> ($past(seen_q) &&
                        $past(bus_wr && bus_addr == OFS_RSTCTL && bus_wdata == FLAG_CLEAR_WORD)));

endmodule

bind wdg_keyed_top wdg_keyed_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rst_req   (rst_req),
  .ctrl      (ctrl_w),
  .cnt       (cnt_w),
  .wd_flag   (wd_flag_w),
  .rst_en    (rst_en_w)
);

// File: tb/test_wdg_keyed_top.sv
module test_wdg_keyed_top;

  logic        clk;
  logic        rst_n;
  logic        bus_rd;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        rst_req;

  int checks;
  int errors;
  bit done;

  wdg_keyed_top i_wdg_keyed_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int div_for(input int cs);
    case (cs)
      0: div_for = 1;
      1: div_for = 4;
      2: div_for = 16;
      3: div_for = 32;
      4: div_for = 64;
      5: div_for = 256;
      6: div_for = 1024;
      default: div_for = 16384;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] e_ctrl, e_cnt, e_rst;
    int n;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(3'd0, v); check("R1 ctrl", v, 16'h0000);
    peek(3'd2, v); check("R1 count", v, 16'h0000);
    peek(3'd4, v); check("R1 rstctl", v, 16'h0000);
    check("R1 rst_req", {15'd0, rst_req}, 16'h0000);
    @(negedge clk);

    // R4 divisors for selects 0..6, R6 hold when stopped
    for (int cs = 0; cs < 7; cs++) begin
      int nd;
      logic [15:0] held;
      nd = div_for(cs);
      wr(3'd2, 16'h5A00);
      wr(3'd0, 16'hA520 | 16'(cs));
      repeat (3 * nd - 1) @(posedge clk);
      peek(3'd2, v); check($sformatf("R4 sel%0d before", cs), v, 16'h0002);
      @(posedge clk);
      peek(3'd2, v); check($sformatf("R4 sel%0d at", cs), v, 16'h0003);
      @(negedge clk);
      wr(3'd0, 16'hA500);
      peek(3'd2, held);
      repeat (40) @(posedge clk);
      peek(3'd2, v); check($sformatf("R6 sel%0d hold", cs), v, held);
      @(negedge clk);
    end

    // R12 counter write restarts prescaler phase (select 2, divide 16)
    wr(3'd2, 16'h5A00);
    wr(3'd0, 16'hA522);
    repeat (10) @(posedge clk);
    @(negedge clk);
    wr(3'd2, 16'h5A00);
    repeat (15) @(posedge clk);
    peek(3'd2, v); check("R12 no early tick", v, 16'h0000);
    @(posedge clk);
    peek(3'd2, v); check("R12 full period", v, 16'h0001);
    @(negedge clk);
    wr(3'd0, 16'hA500);

    // R5 slowest select, one tick from 255; R7 flag; R8 pulse length; R9 enable
    wr(3'd4, 16'h5A40);
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA567);
    repeat (16383) @(posedge clk);
    peek(3'd2, v); check("R5 no early wrap", v, 16'h00FF);
    peek(3'd4, v); check("R9 rste set, R5 no flag yet", v, 16'h0040);
    check("R5 no early rst_req", {15'd0, rst_req}, 16'h0000);
    @(posedge clk);
    peek(3'd2, v); check("R7 counter wraps to 0", v, 16'h0000);
    peek(3'd4, v); check("R7 flag at bit 7", v, 16'h00C0);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      if (rst_req) n++;
      else break;
      @(posedge clk);
      #0.5;
    end
    check("R8 pulse length", 16'(n), 16'd8);
    @(negedge clk);
    wr(3'd0, 16'hA500);

    // R10 clear guard
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R10 clear without read", v, 16'h00C0);
    rd(3'd4);
    wr(3'd4, 16'hA501);
    peek(3'd4, v); check("R10 near-miss word", v, 16'h00C0);
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R10 clear after read", v, 16'h0040);
    wr(3'd4, 16'h5A00);
    peek(3'd4, v); check("R9 rste cleared", v, 16'h0000);
    wr(3'd4, 16'h3C40);
    peek(3'd4, v); check("R9 unkeyed ignored", v, 16'h0000);

    // second wrap with reset enable 0, fastest select
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    wr(3'd0, 16'hA500);
    peek(3'd4, v); check("R7 flag on fast wrap", v, 16'h0080);
    n = 0;
    for (int k = 0; k < 12; k++) begin
      if (rst_req) n++;
      @(posedge clk);
      #0.5;
    end
    check("R8 no pulse when disabled", 16'(n), 16'd0);
    @(negedge clk);
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R10 old read does not arm", v, 16'h0080);
    rd(3'd4);
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R10 clear after new read", v, 16'h0000);

    // R11 interval mode
    wr(3'd4, 16'h5A40);
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA520);
    wr(3'd0, 16'hA580);
    peek(3'd0, v); check("R11 interval status", v, 16'h0080);
    peek(3'd4, v); check("R11 no overflow flag", v, 16'h0040);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      if (rst_req) n++;
      @(posedge clk);
      #0.5;
    end
    check("R11 no rst_req", 16'(n), 16'd0);
    @(negedge clk);
    wr(3'd0, 16'hA500);
    peek(3'd0, v); check("R11 status cleared", v, 16'h0000);
    wr(3'd4, 16'h5A00);

    // R2 R3 R9 random keyed/unkeyed writes, timer kept stopped
    void'($urandom(32'd20240611));
    e_ctrl = 16'h0000; e_cnt = 16'h0000; e_rst = 16'h0000;
    wr(3'd2, 16'h5A00);
    for (int it = 0; it < 40; it++) begin
      int sel;
      logic [15:0] d;
      logic [7:0]  kbyte;
      sel = int'($urandom_range(0, 2));
      d = 16'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        case (sel)
          0: kbyte = 8'hA5;
          default: kbyte = 8'h5A;
        endcase
        d[15:8] = kbyte;
      end
      if (sel == 0) begin
        d[5] = 1'b0;
        if (d[15:8] == 8'hA5) e_ctrl = {8'h00, 1'b0, d[6], 1'b0, 2'b00, d[2:0]};
        wr(3'd0, d);
      end else if (sel == 1) begin
        if (d[15:8] == 8'h5A) e_cnt = {8'h00, d[7:0]};
        wr(3'd2, d);
      end else begin
        if (d[15:8] == 8'h5A) e_rst = {8'h00, 1'b0, d[6], 6'b0};
        wr(3'd4, d);
      end
      peek(3'd0, v); check($sformatf("R2 random %0d data 0x%04h", it, d), v, e_ctrl);
      peek(3'd2, v); check($sformatf("R3 random %0d data 0x%04h", it, d), v, e_cnt);
      peek(3'd4, v); check($sformatf("R9 random %0d data 0x%04h", it, d), v, e_rst);
      @(negedge clk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule